// File: doc/BRIEF.md
# Fast-Lock Interval Timer

This block times the fast-lock window of a fractional-N synthesizer loop. When a new frequency word is loaded and the timer is enabled, it raises a busy flag and holds the loop in its fast-lock state. In that state the charge pump runs at high current and the loop-filter bypass switch is closed. When the programmed interval has elapsed, it drops the flag and the loop returns to its stable, low-current state. The interval is measured in units of 64 reference clock cycles. The unit count is a 7-bit base value plus a compensation term picked by a 2-bit code.

The block runs on the reference clock. The configuration fields are sampled at the load strobe. Two static bits shape the outputs: one forces high pump current at all times, and one keeps the bypass switch open at all times. A power-down input clears the timer and forces both outputs to their stable-mode state.

Top module: `fastlock_timer`

## Requirements
- R1: When `load_stb` is high at a clock edge while `tmc_en`=1 and `pwr_down`=0, and the total unit count is nonzero, `busy` is high from that edge on for exactly 64 × total cycles and then falls.
- R2: The total unit count is `tm_val` + 5 × `tmu_code`. Code values 0, 1, 2 and 3 add 0, 5, 10 and 15 units, so the total can be as high as 142.
- R3: A load while `tmc_en`=0 does not start the timer, and `busy` stays low.
- R4: A load whose total unit count is zero (`tm_val`=0 and `tmu_code`=0) does not start the timer.
- R5: A load during a running interval restarts it, with the full duration that the fields present at the new load give.
- R6: The fields are captured at the load. Changing `tm_val` or `tmu_code` during a run does not change its length.
- R7: With `pwr_down`=0, `cp_high` = `cs_hold` OR (`tmc_en` AND `busy`). The four combinations of `tmc_en` and `cs_hold` give: 0/0 fixed low, 0/1 fixed high, 1/0 high during the run then low, 1/1 fixed high.
- R8: With `pwr_down`=0, `sw_on` is high exactly while `busy` is high and `odsw_off`=0. With `odsw_off`=1 the switch stays off.
- R9: While `pwr_down`=1, `cp_high` and `sw_on` are low and `busy` is cleared at the next edge. Loads during power-down are ignored.
- R10: During and right after reset, `busy` is low and no interval is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_stb | input | 1 | Frequency-word load strobe, one cycle |
| pwr_down | input | 1 | Power-down; clears timer, forces stable outputs |
| tm_val | input | 7 | Base interval in 64-cycle units |
| tmu_code | input | 2 | Compensation code (adds 0/5/10/15 units) |
| tmc_en | input | 1 | Timer enable |
| cs_hold | input | 1 | Force high pump current |
| odsw_off | input | 1 | Keep bypass switch open |
| cp_high | output | 1 | Charge-pump high-current select |
| sw_on | output | 1 | Loop-filter bypass switch enable |
| busy | output | 1 | Fast-lock interval running |

## Verification
The case hardest to reach from the ports is a restart that lands in the middle of a run. The prescaler phase and the unit count must then both start again from zero, and the old target must be discarded. The stimulus reloads 51 cycles into a two-unit run with a three-unit word, and it expects exactly 192 further busy cycles. A shorter count would expose a stale prescaler phase, and 128 would expose a stale target. The longest interval, 142 units, is run in full to cover the widest count, and power-down is asserted in the middle of a run with loads still arriving.

// File: rtl/fl_pkg.sv
package fl_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_st_e;

  // Compensation units contributed by a code value
  function automatic int unsigned comp_units(input int unsigned code,
                                             input int unsigned step);
    return code * step;
  endfunction

endpackage

// File: rtl/fl_prescale.sv
module fl_prescale #(
  parameter int PRE_W = 6
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic tick
);
  localparam logic [PRE_W-1:0] LAST = '1;

  logic [PRE_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt_q + 1'b1;
  end

  assign tick = en && !clr && (cnt_q == LAST);

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/fl_interval.sv
module fl_interval
  import fl_pkg::*;
#(
  parameter int TGT_W = 8
) (
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             clr,
  input  logic             tick,
  input  logic [TGT_W-1:0] target,
  output logic             busy
);
  run_st_e          st_q, st_d;
  logic [TGT_W-1:0] units_q, units_d;
  logic [TGT_W-1:0] tgt_q;
  logic             tgt_en;
  logic [TGT_W-1:0] units_inc;

  assign units_inc = units_q + 1'b1;
  assign tgt_en    = start && !clr;

  always_comb begin
    st_d    = st_q;
    units_d = units_q;
    if (clr) begin
      st_d    = ST_IDLE;
      units_d = '0;
    end else if (start) begin
      st_d    = ST_RUN;
      units_d = '0;
    end else if (st_q == ST_RUN && tick) begin
      if (units_inc == tgt_q) begin
        st_d    = ST_IDLE;
        units_d = '0;
      end else begin
        units_d = units_inc;
      end
    end
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      units_q <= '0;
    end else begin
      st_q    <= st_d;
      units_q <= units_d;
    end
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)      tgt_q <= '0;
    else if (tgt_en) tgt_q <= target;
  end

  assign busy = (st_q == ST_RUN);
endmodule

// File: rtl/fl_drive.sv
module fl_drive (
  input  logic busy,
  input  logic pwr_down,
  input  logic tmc_en,
  input  logic cs_hold,
  input  logic odsw_off,
  output logic cp_high,
  output logic sw_on
);
  always_comb begin
    cp_high = 1'b0;
    sw_on   = 1'b0;
    if (!pwr_down) begin
      cp_high = cs_hold | (tmc_en & busy);
      sw_on   = busy & ~odsw_off;
    end
  end
endmodule

// File: rtl/fastlock_timer.sv
module fastlock_timer
  import fl_pkg::*;
#(
  parameter int PRE_W     = 6,
  parameter int TM_W      = 7,
  parameter int TMU_W     = 2,
  parameter int COMP_STEP = 5
) (
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic             load_stb,
  input  logic             pwr_down,
  input  logic [TM_W-1:0]  tm_val,
  input  logic [TMU_W-1:0] tmu_code,
  input  logic             tmc_en,
  input  logic             cs_hold,
  input  logic             odsw_off,
  output logic             cp_high,
  output logic             sw_on,
  output logic             busy
);
  localparam int TM_MAX   = (1 << TM_W) - 1;
  localparam int COMP_MAX = ((1 << TMU_W) - 1) * COMP_STEP;
  localparam int TGT_W    = $clog2(TM_MAX + COMP_MAX + 1);

  logic [TGT_W-1:0] comp, total;
  logic             start, pre_clr, tick;

  assign comp  = TGT_W'(comp_units(32'(tmu_code), COMP_STEP));
  assign total = TGT_W'(tm_val) + comp;
  assign start = load_stb && tmc_en && !pwr_down && (total != '0);
  assign pre_clr = pwr_down || start;

  fl_prescale #(.PRE_W(PRE_W)) u_pre (
    .ref_clk (ref_clk),
    .rst_n   (rst_n),
    .clr     (pre_clr),
    .en      (busy),
    .tick    (tick)
  );

  fl_interval #(.TGT_W(TGT_W)) u_ivl (
    .ref_clk (ref_clk),
    .rst_n   (rst_n),
    .start   (start),
    .clr     (pwr_down),
    .tick    (tick),
    .target  (total),
    .busy    (busy)
  );

  fl_drive u_drv (
    .busy     (busy),
    .pwr_down (pwr_down),
    .tmc_en   (tmc_en),
    .cs_hold  (cs_hold),
    .odsw_off (odsw_off),
    .cp_high  (cp_high),
    .sw_on    (sw_on)
  );
endmodule

// File: rtl/fastlock_timer_chk.sv
module fastlock_timer_chk #(
  parameter int PRE_W     = 6,
  parameter int TM_W      = 7,
  parameter int TMU_W     = 2,
  parameter int COMP_STEP = 5
) (
  input logic             ref_clk,
  input logic             rst_n,
  input logic             load_stb,
  input logic             pwr_down,
  input logic [TM_W-1:0]  tm_val,
  input logic [TMU_W-1:0] tmu_code,
  input logic             tmc_en,
  input logic             cs_hold,
  input logic             odsw_off,
  input logic             cp_high,
  input logic             sw_on,
  input logic             busy
);
  localparam int CNT_W = TM_W + PRE_W + 4;

  logic             go;
  logic [CNT_W-1:0] len_q, run_cnt;

  assign go = load_stb && tmc_en && !pwr_down && ((tm_val != '0) || (tmu_code != '0));

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q   <= '0;
      run_cnt <= '0;
    end else if (go) begin
      len_q   <= CNT_W'(tm_val) + CNT_W'(tmu_code) * CNT_W'(COMP_STEP);
      run_cnt <= '0;
    end else if (busy) begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  AST_START_RUNS: assert property (@(posedge ref_clk) disable iff (!rst_n)
    go |=> busy); // R1
  AST_RUN_LENGTH: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ($fell(busy) && !$past(pwr_down)) |-> (run_cnt == (len_q << PRE_W))); // R1
  AST_RISE_NEEDS_LOAD: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(busy) |-> $past(load_stb && tmc_en)); // R3
  AST_CP_FIXED_HI: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (cs_hold && !pwr_down) |-> cp_high); // R7
  AST_IDLE_CP_LOW: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (!busy && !cs_hold) |-> !cp_high); // R7
  AST_SW_NEEDS_RUN: assert property (@(posedge ref_clk) disable iff (!rst_n)
    sw_on |-> (busy && !odsw_off)); // R8
  AST_PD_QUIET: assert property (@(posedge ref_clk) disable iff (!rst_n)
    pwr_down |-> (!cp_high && !sw_on)); // R9
  AST_PD_IDLE: assert property (@(posedge ref_clk) disable iff (!rst_n)
    pwr_down |=> !busy); // R9
endmodule

bind fastlock_timer fastlock_timer_chk #(
  .PRE_W(PRE_W), .TM_W(TM_W), .TMU_W(TMU_W), .COMP_STEP(COMP_STEP)
) u_chk (
  .ref_clk  (ref_clk),
  .rst_n    (rst_n),
  .load_stb (load_stb),
  .pwr_down (pwr_down),
  .tm_val   (tm_val),
  .tmu_code (tmu_code),
  .tmc_en   (tmc_en),
  .cs_hold  (cs_hold),
  .odsw_off (odsw_off),
  .cp_high  (cp_high),
  .sw_on    (sw_on),
  .busy     (busy)
);

// File: tb/sim_fastlock_timer.sv
`timescale 1ns/1ps
module sim_fastlock_timer;
  localparam time CLK_P = 5ns;

  logic       ref_clk = 1'b0;
  logic       rst_n;
  logic       load_stb, pwr_down, tmc_en, cs_hold, odsw_off;
  logic [6:0] tm_val;
  logic [1:0] tmu_code;
  logic       cp_high, sw_on, busy;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_P/2) ref_clk = ~ref_clk;

  fastlock_timer u0 (
    .ref_clk (ref_clk), .rst_n (rst_n), .load_stb (load_stb),
    .pwr_down (pwr_down), .tm_val (tm_val), .tmu_code (tmu_code),
    .tmc_en (tmc_en), .cs_hold (cs_hold), .odsw_off (odsw_off),
    .cp_high (cp_high), .sw_on (sw_on), .busy (busy)
  );

  // {tm[7], tmu[2], tmc, cs, odsw, exp_len[14], cp_run, cp_idle, sw_run}
  localparam logic [28:0] VEC [0:7] = '{
    {7'd1,   2'd0, 1'b1, 1'b0, 1'b0, 14'd64,   1'b1, 1'b0, 1'b1},
    {7'd3,   2'd1, 1'b1, 1'b1, 1'b0, 14'd512,  1'b1, 1'b1, 1'b1},
    {7'd2,   2'd2, 1'b1, 1'b0, 1'b1, 14'd768,  1'b1, 1'b0, 1'b0},
    {7'd5,   2'd0, 1'b0, 1'b0, 1'b0, 14'd0,    1'b0, 1'b0, 1'b0},
    {7'd5,   2'd0, 1'b0, 1'b1, 1'b0, 14'd0,    1'b1, 1'b1, 1'b0},
    {7'd127, 2'd3, 1'b1, 1'b0, 1'b0, 14'd9088, 1'b1, 1'b0, 1'b1},
    {7'd0,   2'd1, 1'b1, 1'b0, 1'b0, 14'd320,  1'b1, 1'b0, 1'b1},
    {7'd0,   2'd0, 1'b1, 1'b0, 1'b0, 14'd0,    1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // Caller sits just after a falling edge; returns just after the next one.
  task automatic pulse_load();
    load_stb = 1'b1;
    @(negedge ref_clk);
    load_stb = 1'b0;
  endtask

  task automatic measure(output int n, output bit cp0, output bit sw0);
    n = 0; cp0 = cp_high; sw0 = sw_on;
    while (busy && n < 20000) begin
      n++;
      @(negedge ref_clk);
    end
  endtask

  initial begin
    int n;
    bit cp0, sw0;
    rst_n = 1'b0; load_stb = 1'b0; pwr_down = 1'b0; tmc_en = 1'b0;
    cs_hold = 1'b0; odsw_off = 1'b0; tm_val = '0; tmu_code = '0;
    repeat (3) @(negedge ref_clk);
    chk("R10 busy in reset", busy, 0);
    chk("R10 cp in reset", cp_high, 0);
    chk("R10 sw in reset", sw_on, 0);
    rst_n = 1'b1;
    @(negedge ref_clk);
    chk("R10 busy after reset", busy, 0);

    for (int i = 0; i < 8; i++) begin
      tm_val   = VEC[i][28:22];
      tmu_code = VEC[i][21:20];
      tmc_en   = VEC[i][19];
      cs_hold  = VEC[i][18];
      odsw_off = VEC[i][17];
      @(negedge ref_clk);
      pulse_load();
      measure(n, cp0, sw0);
      chk("R1 R2 R3 R4 interval length", n, int'(VEC[i][16:3]));
      if (VEC[i][16:3] != 0) begin
        chk("R7 cp during run", cp0, VEC[i][2]);
        chk("R8 sw during run", sw0, VEC[i][0]);
      end
      chk("R7 cp after run", cp_high, VEC[i][1]);
      chk("R8 sw after run", sw_on, 0);
    end

    // R5: restart mid-run with a new word
    tmc_en = 1'b1; cs_hold = 1'b0; odsw_off = 1'b0; tm_val = 7'd2; tmu_code = 2'd0;
    @(negedge ref_clk);
    pulse_load();
    repeat (50) @(negedge ref_clk);
    tm_val = 7'd3;
    pulse_load();
    measure(n, cp0, sw0);
    chk("R5 restart length", n, 192);

    // R6: fields changed during a run have no effect
    tm_val = 7'd1;
    @(negedge ref_clk);
    pulse_load();
    tm_val = 7'd100; tmu_code = 2'd3;
    measure(n, cp0, sw0);
    chk("R6 captured length", n, 64);

    // R9: power-down mid-run, loads ignored
    tm_val = 7'd10; tmu_code = 2'd0;
    @(negedge ref_clk);
    pulse_load();
    repeat (20) @(negedge ref_clk);
    chk("R9 running before pd", busy, 1);
    pwr_down = 1'b1; cs_hold = 1'b1;
    #1;
    chk("R9 cp forced low", cp_high, 0);
    chk("R9 sw forced low", sw_on, 0);
    @(negedge ref_clk);
    chk("R9 busy cleared", busy, 0);
    pulse_load();
    chk("R9 load ignored in pd", busy, 0);
    pwr_down = 1'b0;
    @(negedge ref_clk);
    chk("R9 no run after pd", busy, 0);
    chk("R7 cs forces high", cp_high, 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge ref_clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule